// File: doc/BRIEF.md
# SPI Frame Buffer Access Controller

This block lets an SPI host (mode 0, MSB first) burst-read and burst-write one packet held in a shared 128-byte buffer. The host pulls the active-low select low and sends a command byte. While that byte is shifting in, the block returns a status byte supplied on `phy_status`. A read command then streams out the stored length byte, the payload, and three receive-metadata bytes. These are link quality, energy level and receive status. A write command stores the next byte as the frame length and the bytes after it as payload, starting at buffer address 0. An address counter is cleared at the start of every access and steps once per payload byte.

A receive-side load port lets the local radio path deposit a length, payload bytes and metadata while no SPI access is in progress. The SPI lines are oversampled by the system clock. Each SCLK high phase and each low phase must last at least 6 system clock cycles. Access violations produce a one-cycle interrupt pulse. After a violation the rest of the access is ignored.

The controller is built around one state machine. Its states are IDLE, CMD, RD_LEN, RD_PAY, RD_LQI, RD_ED, RD_STS, RD_OVER, WR_LEN, WR_PAY and DRAIN.
- IDLE leaves for CMD when select is seen low.
- CMD goes to RD_LEN on a read command, to WR_LEN on a write command, and to DRAIN otherwise.
- RD_LEN goes to RD_PAY, or straight to RD_LQI when the length is 0.
- RD_PAY goes to RD_LQI after the last payload byte.
- RD_LQI, RD_ED, RD_STS and RD_OVER follow one another, one per byte.
- RD_OVER goes to DRAIN with a violation when another byte is clocked.
- WR_LEN goes to WR_PAY, or to DRAIN with a violation when the length exceeds 127.
- WR_PAY goes to DRAIN with a violation on a 128th payload byte.
- Every state returns to IDLE when select rises.

Top module: `spi_frame_buffer`

## Requirements
- R1: Command byte 0xA0 selects frame read and 0xC0 selects frame write. Any other command makes the rest of the access ignored: MISO returns 0x00 after the command byte, nothing is stored, and no interrupt is raised.
- R2: The `phy_status` value sampled when select falls is shifted out on MISO during the command byte (mode 0, MSB first).
- R3: A read returns, after the status byte, the stored length byte, then that many payload bytes from address 0 upward, then link quality, energy level and receive status. A read is 5 + length bytes long.
- R4: On a write, the second byte is stored as the length when it is 127 or less. The following bytes overwrite the buffer from address 0 upward, for up to 127 payload bytes (129 bytes in all).
- R5: Raising select at any byte boundary ends the access. Bytes already written stay stored, and the next read starts again with the length byte.
- R6: After reset the stored length and the three metadata bytes are 0, so a read returns status, 0x00, 0x00, 0x00, 0x00. The interrupt is low and MISO is 0.
- R7: A write length byte above 127 raises the interrupt. The stored length and the buffer stay unchanged.
- R8: A 128th payload byte in one write (the 130th byte) raises the interrupt and is not stored.
- R9: Any byte clocked after the receive status byte of a read raises the interrupt. MISO returns 0x00 for such bytes.
- R10: The interrupt is a single-cycle pulse and fires at most once per access. Later bytes of that access are ignored.
- R11: The receive-side port updates length, payload and metadata only while select is high. The receive status byte is kept as given: bit 7 is the CRC-valid flag, bits 6:4 are the transaction status, and the low bits are kept as given. Requests made during an SPI access are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | Active-low select framing each access |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| phy_status | input | 8 | Status byte returned during the command byte |
| rcv_len_we | input | 1 | Receive port: load length |
| rcv_len | input | 8 | Receive port: length value |
| rcv_pay_we | input | 1 | Receive port: write one payload byte |
| rcv_pay_addr | input | 7 | Receive port: payload address |
| rcv_pay_data | input | 8 | Receive port: payload data |
| rcv_meta_we | input | 1 | Receive port: load the three metadata bytes |
| rcv_lqi | input | 8 | Receive port: link quality value |
| rcv_ed | input | 8 | Receive port: energy level value |
| rcv_status | input | 8 | Receive port: receive status byte |
| irq_violation | output | 1 | One-cycle access-violation pulse |

## Verification
Frames are read back after several kinds of load:
- Reset, which tells an empty length from uninitialised data.
- The receive port, which checks the order of the trailer bytes.
- Short, full-length and aborted SPI writes. An aborted write shows that bytes stored before the abort survive while the length byte is still taken.

Violation patterns are also tried:
- An oversize length.
- A 130th write byte.
- Bytes read past the trailer.
- An unknown command, which must stay silent.

These separate each violation cause from the legal 129-byte write and 132-byte read that sit just under each limit. Receive-port loads issued while select is low show whether the port is correctly locked out during an access.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_RD_LEN,
        ST_RD_PAY,
        ST_RD_LQI,
        ST_RD_ED,
        ST_RD_STS,
        ST_RD_OVER,
        ST_WR_LEN,
        ST_WR_PAY,
        ST_DRAIN
    } fbc_state_e;

    typedef struct packed {
        logic [7:0] lqi;
        logic [7:0] ed;
        logic [7:0] status;
    } rx_meta_t;

endpackage

// File: rtl/fbc_spi_shift.sv
module fbc_spi_shift #(
    parameter int SYNC_STAGES = 2,
    parameter int W           = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         cs_n,
    input  logic         mosi,
    input  logic [W-1:0] tx_first,
    input  logic [W-1:0] tx_next,
    output logic         miso,
    output logic         sel,
    output logic         byte_done,
    output logic [W-1:0] rx_byte
);
    localparam int BW = $clog2(W);

    // bit 2: sclk, bit 1: cs_n, bit 0: mosi
    logic [SYNC_STAGES-1:0][2:0] sync_q;
    logic                        sclk_d, cs_d;
    logic                        sclk_s, cs_s, mosi_s;
    logic                        sel_start, rise, fall;
    logic [BW-1:0]               bit_cnt;
    logic [W-2:0]                rx_sr;
    logic [W-1:0]                tx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{3'b010}};
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], {sclk, cs_n, mosi}};
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign sclk_s    = sync_q[SYNC_STAGES-1][2];
    assign cs_s      = sync_q[SYNC_STAGES-1][1];
    assign mosi_s    = sync_q[SYNC_STAGES-1][0];
    assign sel       = ~cs_s;
    assign sel_start = cs_d & ~cs_s;
    assign rise      = sel & sclk_s & ~sclk_d;
    assign fall      = sel & ~sclk_s & sclk_d;
    assign miso      = tx_sr[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else begin
                if (sel_start) begin
                    tx_sr <= tx_first;
                end else if (fall) begin
                    if (bit_cnt == '0) tx_sr <= tx_next;
                    else               tx_sr <= {tx_sr[W-2:0], 1'b0};
                end
                if (rise) begin
                    rx_sr   <= {rx_sr[W-3:0], mosi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == BW'(W-1)) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {rx_sr, mosi_s};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fbc_buffer.sv
module fbc_buffer #(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/fbc_ctrl.sv
module fbc_ctrl
    import fbc_pkg::*;
#(
    parameter int         MAX_LEN = 127,
    parameter int         W       = 8,
    parameter int         AW      = 7,
    parameter logic [7:0] CMD_RD  = 8'hA0,
    parameter logic [7:0] CMD_WR  = 8'hC0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          byte_done,
    input  logic [W-1:0]  rx_byte,
    input  logic [W-1:0]  mem_rdata,
    input  logic          rcv_len_we,
    input  logic [W-1:0]  rcv_len,
    input  logic          rcv_pay_we,
    input  logic [AW-1:0] rcv_pay_addr,
    input  logic [W-1:0]  rcv_pay_data,
    input  logic          rcv_meta_we,
    input  rx_meta_t      rcv_meta,
    output logic [W-1:0]  tx_next,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [W-1:0]  mem_wdata,
    output logic [AW-1:0] mem_raddr,
    output logic          irq,
    output fbc_state_e    st,
    output logic [AW-1:0] addr
);
    fbc_state_e   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [W-1:0] len_q;
    rx_meta_t     meta_q;
    logic         irq_q;
    logic         viol, spi_we, len_we, addr_clr, addr_inc, rcv_ok;
    logic         last_pay;

    assign last_pay = (W'(addr_q) + W'(1)) == len_q;
    assign rcv_ok   = (state_q == ST_IDLE) && !sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        viol     = 1'b0;
        spi_we   = 1'b0;
        len_we   = 1'b0;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        tx_next  = '0;
        if (!sel) begin
            state_d  = ST_IDLE;
            addr_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d  = ST_CMD;
                    addr_clr = 1'b1;
                end
                ST_CMD: if (byte_done) begin
                    if (rx_byte == CMD_RD)      state_d = ST_RD_LEN;
                    else if (rx_byte == CMD_WR) state_d = ST_WR_LEN;
                    else                        state_d = ST_DRAIN;
                end
                ST_RD_LEN: if (byte_done) begin
                    state_d = (len_q == '0) ? ST_RD_LQI : ST_RD_PAY;
                end
                ST_RD_PAY: if (byte_done) begin
                    addr_inc = 1'b1;
                    if (last_pay) state_d = ST_RD_LQI;
                end
                ST_RD_LQI:  if (byte_done) state_d = ST_RD_ED;
                ST_RD_ED:   if (byte_done) state_d = ST_RD_STS;
                ST_RD_STS:  if (byte_done) state_d = ST_RD_OVER;
                ST_RD_OVER: if (byte_done) begin
                    viol    = 1'b1;
                    state_d = ST_DRAIN;
                end
                ST_WR_LEN: if (byte_done) begin
                    if (rx_byte > W'(MAX_LEN)) begin
                        viol    = 1'b1;
                        state_d = ST_DRAIN;
                    end else begin
                        len_we  = 1'b1;
                        state_d = ST_WR_PAY;
                    end
                end
                ST_WR_PAY: if (byte_done) begin
                    if (addr_q == AW'(MAX_LEN)) begin
                        viol    = 1'b1;
                        state_d = ST_DRAIN;
                    end else begin
                        spi_we   = 1'b1;
                        addr_inc = 1'b1;
                    end
                end
                ST_DRAIN: state_d = ST_DRAIN;
                default:  state_d = ST_IDLE;
            endcase

            unique case (state_q)
                ST_RD_LEN: tx_next = len_q;
                ST_RD_PAY: tx_next = mem_rdata;
                ST_RD_LQI: tx_next = meta_q.lqi;
                ST_RD_ED:  tx_next = meta_q.ed;
                ST_RD_STS: tx_next = meta_q.status;
                default:   tx_next = '0;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
            meta_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= viol;
            if (addr_clr)      addr_q <= '0;
            else if (addr_inc) addr_q <= addr_q + 1'b1;
            if (len_we)                      len_q <= rx_byte;
            else if (rcv_ok && rcv_len_we)   len_q <= rcv_len;
            if (rcv_ok && rcv_meta_we)       meta_q <= rcv_meta;
        end
    end

    // SPI write has priority over the receive-side port
    assign mem_we    = spi_we | (rcv_ok & rcv_pay_we);
    assign mem_waddr = spi_we ? addr_q  : rcv_pay_addr;
    assign mem_wdata = spi_we ? rx_byte : rcv_pay_data;
    assign mem_raddr = addr_q;
    assign irq       = irq_q;
    assign st        = state_q;
    assign addr      = addr_q;

endmodule

// File: rtl/spi_frame_buffer.sv
module spi_frame_buffer
    import fbc_pkg::*;
#(
    parameter int         BUF_DEPTH   = 128,
    parameter int         MAX_LEN     = 127,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] CMD_RD      = 8'hA0,
    parameter logic [7:0] CMD_WR      = 8'hC0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sclk,
    input  logic                         cs_n,
    input  logic                         mosi,
    output logic                         miso,
    input  logic [7:0]                   phy_status,
    input  logic                         rcv_len_we,
    input  logic [7:0]                   rcv_len,
    input  logic                         rcv_pay_we,
    input  logic [$clog2(BUF_DEPTH)-1:0] rcv_pay_addr,
    input  logic [7:0]                   rcv_pay_data,
    input  logic                         rcv_meta_we,
    input  logic [7:0]                   rcv_lqi,
    input  logic [7:0]                   rcv_ed,
    input  logic [7:0]                   rcv_status,
    output logic                         irq_violation
);
    localparam int W      = 8;
    localparam int ADDR_W = $clog2(BUF_DEPTH);

    logic              sel, byte_done, mem_we;
    logic [W-1:0]      rx_byte, tx_next, mem_wdata, mem_rdata;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr, addr;
    fbc_state_e        st;
    rx_meta_t          rcv_meta;

    assign rcv_meta = '{lqi: rcv_lqi, ed: rcv_ed, status: rcv_status};

    fbc_spi_shift #(.SYNC_STAGES(SYNC_STAGES), .W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .tx_first  (phy_status),
        .tx_next   (tx_next),
        .miso      (miso),
        .sel       (sel),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    fbc_ctrl #(
        .MAX_LEN (MAX_LEN),
        .W       (W),
        .AW      (ADDR_W),
        .CMD_RD  (CMD_RD),
        .CMD_WR  (CMD_WR)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sel),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .mem_rdata    (mem_rdata),
        .rcv_len_we   (rcv_len_we),
        .rcv_len      (rcv_len),
        .rcv_pay_we   (rcv_pay_we),
        .rcv_pay_addr (rcv_pay_addr),
        .rcv_pay_data (rcv_pay_data),
        .rcv_meta_we  (rcv_meta_we),
        .rcv_meta     (rcv_meta),
        .tx_next      (tx_next),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_wdata    (mem_wdata),
        .mem_raddr    (mem_raddr),
        .irq          (irq_violation),
        .st           (st),
        .addr         (addr)
    );

    fbc_buffer #(.DEPTH(BUF_DEPTH), .W(W), .AW(ADDR_W)) u_buf (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (mem_waddr),
        .wr_data (mem_wdata),
        .rd_addr (mem_raddr),
        .rd_data (mem_rdata)
    );

endmodule

// File: rtl/spi_frame_buffer_chk.sv
module spi_frame_buffer_chk
    import fbc_pkg::*;
#(
    parameter int AW      = 7,
    parameter int MAX_LEN = 127
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel,
    input logic          byte_done,
    input logic [7:0]    rx_byte,
    input fbc_state_e    st,
    input logic [AW-1:0] addr,
    input logic          mem_we,
    input logic          irq
);
    // R10: single-cycle pulse
    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5: dropping select returns the machine to idle
    assert_abort_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (st == ST_IDLE));

    // R3 / R4: address counter starts from zero
    assert_addr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CMD) |-> (addr == '0));

    // R11: only SPI payload writes touch the buffer during an access
    assert_rcv_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && st != ST_WR_PAY) |-> !mem_we);

    // R7: oversize length raises the interrupt and drains
    assert_bad_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && st == ST_WR_LEN && byte_done && rx_byte > 8'(MAX_LEN)) |=> (irq && st == ST_DRAIN));

    // R8: payload byte past the limit raises the interrupt, no write
    assert_wr_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && st == ST_WR_PAY && byte_done && addr == AW'(MAX_LEN)) |-> !mem_we);
    assert_wr_overflow_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && st == ST_WR_PAY && byte_done && addr == AW'(MAX_LEN)) |=> irq);

    // R9: byte after the trailer raises the interrupt
    assert_rd_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && st == ST_RD_OVER && byte_done) |=> irq);

endmodule

bind spi_frame_buffer spi_frame_buffer_chk #(.AW(ADDR_W), .MAX_LEN(MAX_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .st        (st),
    .addr      (addr),
    .mem_we    (mem_we),
    .irq       (irq_violation)
);

// File: tb/spi_frame_buffer_tb.sv
`timescale 1ns/1ps
module spi_frame_buffer_tb;
    localparam int HP = 8;
    localparam logic [7:0] C_RD = 8'hA0;
    localparam logic [7:0] C_WR = 8'hC0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [7:0] phy_status = 8'h5A;
    logic rcv_len_we = 1'b0, rcv_pay_we = 1'b0, rcv_meta_we = 1'b0;
    logic [7:0] rcv_len = '0, rcv_pay_data = '0, rcv_lqi = '0, rcv_ed = '0, rcv_status = '0;
    logic [6:0] rcv_pay_addr = '0;
    logic irq_violation;

    always #4 clk = ~clk;

    spi_frame_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .phy_status(phy_status), .rcv_len_we(rcv_len_we), .rcv_len(rcv_len),
        .rcv_pay_we(rcv_pay_we), .rcv_pay_addr(rcv_pay_addr), .rcv_pay_data(rcv_pay_data),
        .rcv_meta_we(rcv_meta_we), .rcv_lqi(rcv_lqi), .rcv_ed(rcv_ed), .rcv_status(rcv_status),
        .irq_violation(irq_violation)
    );

    int n_cmp = 0, n_bad = 0;
    int irq_cnt = 0, irq_run = 0, irq_max_run = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];

    // model of stored frame
    logic [7:0] m_len = '0, m_lqi = '0, m_ed = '0, m_sts = '0;
    logic [7:0] m_pay [128];

    always @(posedge clk) begin
        if (irq_violation) begin
            irq_cnt++;
            irq_run++;
            if (irq_run > irq_max_run) irq_max_run = irq_run;
        end else begin
            irq_run = 0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: compares bytes as they come off MISO
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (g !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", t, g, e);
                end
            end
        end
    end

    task automatic xfer(input logic [7:0] tx, input bit chk, input logic [7:0] exp, input string tag);
        logic [7:0] rx;
        if (chk) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HP) @(negedge clk);
            sclk = 1'b1;
            rx[i] = miso;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        if (chk) got_q.push_back(rx);
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic read_full(input int extra);
        cs_low();
        xfer(C_RD, 1, phy_status, "R2 status during command");
        xfer(8'h00, 1, m_len, "R3 length byte");
        for (int i = 0; i < int'(m_len); i++) xfer(8'h00, 1, m_pay[i], "R3 payload byte");
        xfer(8'h00, 1, m_lqi, "R3 link quality");
        xfer(8'h00, 1, m_ed, "R3 energy level");
        xfer(8'h00, 1, m_sts, "R3 receive status");
        for (int i = 0; i < extra; i++) xfer(8'h00, 1, 8'h00, "R9 past end reads zero");
        cs_high();
    endtask

    task automatic write_frame(input logic [7:0] len, input int npay, input logic [7:0] seed, input bit close);
        cs_low();
        xfer(C_WR, 0, 8'h00, "");
        xfer(len, 0, 8'h00, "");
        if (len <= 8'd127) m_len = len;
        for (int i = 0; i < npay; i++) begin
            logic [7:0] v;
            v = seed + 8'(i * 3);
            xfer(v, 0, 8'h00, "");
            if (len <= 8'd127 && i < 127) m_pay[i] = v;
        end
        if (close) cs_high();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        for (int i = 0; i < 128; i++) m_pay[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R6: reset state at the ports
        check("R6 irq low after reset", int'(irq_violation), 0);
        check("R6 miso low after reset", int'(miso), 0);
        cs_low();
        xfer(C_RD, 1, 8'h5A, "R6 status byte");
        xfer(8'h00, 1, 8'h00, "R6 length zero");
        xfer(8'h00, 1, 8'h00, "R6 lqi zero");
        xfer(8'h00, 1, 8'h00, "R6 ed zero");
        xfer(8'h00, 1, 8'h00, "R6 rx status zero");
        cs_high();

        // R11 / R3: receive-side load then read
        @(negedge clk);
        rcv_len = 8'd3; rcv_len_we = 1'b1;
        rcv_lqi = 8'h7E; rcv_ed = 8'h21; rcv_status = 8'hA3; rcv_meta_we = 1'b1;
        @(negedge clk);
        rcv_len_we = 1'b0; rcv_meta_we = 1'b0;
        for (int i = 0; i < 3; i++) begin
            rcv_pay_addr = 7'(i);
            rcv_pay_data = 8'hA5 ^ 8'(i * 17);
            rcv_pay_we = 1'b1;
            m_pay[i] = 8'hA5 ^ 8'(i * 17);
            @(negedge clk);
        end
        rcv_pay_we = 1'b0;
        m_len = 8'd3; m_lqi = 8'h7E; m_ed = 8'h21; m_sts = 8'hA3;
        phy_status = 8'hC3;
        read_full(0);

        // R5: abort after the length byte, then read again from the start
        cs_low();
        xfer(C_RD, 1, phy_status, "R5 status before abort");
        xfer(8'h00, 1, m_len, "R5 length before abort");
        cs_high();
        read_full(0);

        // R5: aborted write keeps the bytes already stored
        write_frame(8'd5, 2, 8'h40, 1);
        read_full(0);

        // R4: full short write overwrites
        phy_status = 8'h0F;
        write_frame(8'd4, 4, 8'h90, 1);
        read_full(0);
        check("R4 no irq on legal write", irq_cnt, 0);

        // R1: unknown command is ignored
        cs_low();
        xfer(8'h33, 1, phy_status, "R1 status during unknown command");
        xfer(8'h07, 1, 8'h00, "R1 miso zero after unknown command");
        xfer(8'h09, 1, 8'h00, "R1 miso zero after unknown command");
        cs_high();
        check("R1 no irq for unknown command", irq_cnt, 0);
        read_full(0);

        // R7: oversize length
        base = irq_cnt;
        write_frame(8'd200, 3, 8'h11, 1);
        check("R7 irq on oversize length", irq_cnt - base, 1);
        read_full(0);

        // R8: 129-byte write is legal, 130th byte violates
        base = irq_cnt;
        write_frame(8'd127, 127, 8'h01, 0);
        repeat (HP) @(negedge clk);
        check("R8 no irq at 129 bytes", irq_cnt - base, 0);
        xfer(8'hEE, 0, 8'h00, "");
        cs_high();
        check("R8 irq on 130th byte", irq_cnt - base, 1);

        // R9 / R10: 132-byte read legal, then one irq for extra bytes
        base = irq_cnt;
        read_full(0);
        check("R9 no irq on full 132-byte read", irq_cnt - base, 0);
        read_full(2);
        check("R10 exactly one irq per access", irq_cnt - base, 1);

        // R11: receive-side port locked out while selected
        cs_low();
        @(negedge clk);
        rcv_len = 8'd9; rcv_len_we = 1'b1;
        rcv_lqi = 8'h01; rcv_ed = 8'h02; rcv_status = 8'h03; rcv_meta_we = 1'b1;
        rcv_pay_addr = 7'd0; rcv_pay_data = 8'hFF; rcv_pay_we = 1'b1;
        @(negedge clk);
        rcv_len_we = 1'b0; rcv_meta_we = 1'b0; rcv_pay_we = 1'b0;
        cs_high();
        read_full(0);

        repeat (20) @(negedge clk);
        check("R10 irq pulse width", irq_max_run, 1);
        check("R11 queue drained", exp_q.size(), 0);
        finish_run();
    end

endmodule